// File: doc/BRIEF.md
# Phase-Accumulator PWM Bank with Staged Update

This block provides a parameterized number of independent PWM output channels. Each channel has a single 32-bit control register that a simple read/write port reaches. A channel does not count to a terminal value to set its period. Instead, a phase accumulator adds a programmable base-unit increment on every clock. A carry out of that add marks the start of a new output cycle. The duty cycle comes from an 8-bit divisor compared against the top byte of the accumulator. The divisor uses an inverted encoding: larger values give a shorter high time.

Software writes new period and duty fields into a shadow copy of the register. To make them take effect, it also sets an update-request bit. The hardware holds that bit set until the next output-cycle boundary. At the boundary it copies the shadow fields into the active copy that drives the output, then clears the bit. Software polls the bit to see when the hand-off is done. While the bit is still pending, any further write to the channel is dropped, so a hasty second write cannot leave the channel in a mixed state.

Top module: `pwm_acc_bank`

## Requirements
- R1: After reset every channel reads 0x00000000 and every pwm_o bit is low.
- R2: Register layout: bit 31 enable, bit 30 update request, bits [8+BU_W-1:8] base-unit increment, bits [7:0] on-time divisor. Reserved bits between the base field and bit 30 read as 0 whatever was written.
- R3: If the update bit is set, the channel is enabled and the active base unit is nonzero, the update bit stays set and readable until the next accumulator carry. On that clock edge the shadow fields are loaded into the active copy and the update bit clears.
- R4: A write to a channel whose update bit is set is ignored entirely: enable, update bit and fields keep their values.
- R5: While enable is 0, pwm_o for that channel is low and its accumulator is held at 0. A pending update commits on the next clock edge.
- R6: If the active base unit is 0, a pending update commits on the next clock edge, because no carry can occur.
- R7: The accumulator is BU_W bits wide and wraps modulo 2^BU_W. The output period in clocks is 2^BU_W / base. For example, with BU_W=16 a base of 0x1000 gives 16 clocks, 0x0200 gives 128 clocks and 0x4000 gives 4 clocks.
- R8: pwm_o is high when the accumulator's top 8 bits are greater than or equal to the active divisor. A divisor of 0xFF forces the output low, and 0x00 makes it high on every cycle.
- R9: Channels are independent. Channel k is at byte address k*0x400, and bits [9:0] of the address must be zero for a read or write to hit the channel.
- R10: Writing fields without the update bit changes only the shadow copy (visible on read) and does not alter the running output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one clock per write |
| addr_i | input | ADDR_W | Byte address; the channel index is in bits [ADDR_W-1:10] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read-back of the addressed channel register |
| pwm_o | output | N_CH | One PWM output per channel |

## Verification
If the active copy is corrupted or loaded at the wrong moment, the high-time count taken over one full period at pwm_o differs from the ratio expected for the committed settings. This shows up within one period of the commit. If the update bit is held or released wrongly, read-back exposes it at once. It then either stays set past a period or clears before a write that was meant to be dropped, which lets that write change the register. The checks on channel independence read and count one channel while the other is being reprogrammed, so state that leaks between channels appears in the very next measurement window.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;
  localparam int EN_BIT     = 31;
  localparam int UPD_BIT    = 30;
  localparam int BASE_LSB   = 8;
  localparam int DUTY_W     = 8;
  localparam int STRIDE_LSB = 10;
  localparam logic [DUTY_W-1:0] DUTY_OFF = 8'hFF;
endpackage

// File: rtl/pwm_acc_regs.sv
module pwm_acc_regs
  import pwm_acc_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              wrap_i,
  output logic              en_o,
  output logic              upd_o,
  output logic [BU_W-1:0]   base_act_o,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic [31:0]       rdata_o
);
  localparam logic [31:0] WR_MASK = (32'(1) << EN_BIT) | (32'(1) << UPD_BIT)
                                  | (((32'(1) << BU_W) - 32'(1)) << BASE_LSB)
                                  | ((32'(1) << DUTY_W) - 32'(1));

  logic [31:0]       reg_q;
  logic [BU_W-1:0]   base_act_q;
  logic [DUTY_W-1:0] duty_act_q;
  logic              commit;

  // commit when a boundary comes, or when none ever will
  assign commit = reg_q[UPD_BIT] & (~reg_q[EN_BIT] | wrap_i | (base_act_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q      <= '0;
      base_act_q <= '0;
      duty_act_q <= '0;
    end else if (commit) begin
      base_act_q       <= reg_q[BASE_LSB +: BU_W];
      duty_act_q       <= reg_q[DUTY_W-1:0];
      reg_q[UPD_BIT]   <= 1'b0;
    end else if (wr_i && !reg_q[UPD_BIT]) begin
      reg_q <= wdata_i & WR_MASK;
    end
  end

  assign en_o       = reg_q[EN_BIT];
  assign upd_o      = reg_q[UPD_BIT];
  assign base_act_o = base_act_q;
  assign duty_act_o = duty_act_q;
  assign rdata_o    = reg_q;
endmodule

// File: rtl/pwm_acc_core.sv
module pwm_acc_core
  import pwm_acc_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BU_W-1:0]   base_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              wrap_o,
  output logic              pwm_o
);
  logic [BU_W-1:0] acc_q;
  logic [BU_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, base_i};
  assign wrap_o = en_i & sum[BU_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum[BU_W-1:0];
    else           acc_q <= '0;
  end

  assign pwm_o = en_i & (duty_i != DUTY_OFF) & (acc_q[BU_W-1 -: DUTY_W] >= duty_i);
endmodule

// File: rtl/pwm_acc_chan.sv
module pwm_acc_chan
  import pwm_acc_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        en_o,
  output logic        upd_o,
  output logic        wrap_o,
  output logic        act_zero_o,
  output logic        pwm_o
);
  logic [BU_W-1:0]   base_act;
  logic [DUTY_W-1:0] duty_act;

  pwm_acc_regs #(.BU_W(BU_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .wrap_i     (wrap_o),
    .en_o       (en_o),
    .upd_o      (upd_o),
    .base_act_o (base_act),
    .duty_act_o (duty_act),
    .rdata_o    (rdata_o)
  );

  pwm_acc_core #(.BU_W(BU_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_o),
    .base_i (base_act),
    .duty_i (duty_act),
    .wrap_o (wrap_o),
    .pwm_o  (pwm_o)
  );

  assign act_zero_o = (base_act == '0);
endmodule

// File: rtl/pwm_acc_bank.sv
module pwm_acc_bank
  import pwm_acc_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int BU_W   = 16,
  parameter int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  parameter int ADDR_W = STRIDE_LSB + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  logic [CH_W-1:0] ch_idx;
  logic            off_ok;
  logic [N_CH-1:0] hit_w, en_w, upd_w, wrap_w, act_zero_w;
  logic [31:0]     rd_arr [N_CH];

  assign ch_idx = addr_i[ADDR_W-1:STRIDE_LSB];
  assign off_ok = (addr_i[STRIDE_LSB-1:0] == '0);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign hit_w[g] = wr_en_i & off_ok & (int'(ch_idx) == g);
    pwm_acc_chan #(.BU_W(BU_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (hit_w[g]),
      .wdata_i    (wdata_i),
      .rdata_o    (rd_arr[g]),
      .en_o       (en_w[g]),
      .upd_o      (upd_w[g]),
      .wrap_o     (wrap_w[g]),
      .act_zero_o (act_zero_w[g]),
      .pwm_o      (pwm_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++)
      if (off_ok && int'(ch_idx) == i) rdata_o = rd_arr[i];
  end
endmodule

// File: rtl/pwm_acc_chk.sv
module pwm_acc_chk #(
  parameter int N_CH = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] hit_w,
  input logic [N_CH-1:0] en_w,
  input logic [N_CH-1:0] upd_w,
  input logic [N_CH-1:0] wrap_w,
  input logic [N_CH-1:0] act_zero_w,
  input logic [N_CH-1:0] pwm_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    p_dis_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_w[g] |-> !pwm_o[g]);
    p_dis_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_w[g] && upd_w[g]) |=> !upd_w[g]);
    p_zero_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_w[g] && act_zero_w[g]) |=> !upd_w[g]);
    p_upd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_w[g] && en_w[g] && !act_zero_w[g] && !wrap_w[g]) |=> upd_w[g]);
    p_pend_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_w[g] && upd_w[g]) |=> (en_w[g] == $past(en_w[g])));
    p_wrap_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_w[g] |-> en_w[g]);
  end
endmodule

bind pwm_acc_bank pwm_acc_chk #(.N_CH(N_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hit_w      (hit_w),
  .en_w       (en_w),
  .upd_w      (upd_w),
  .wrap_w     (wrap_w),
  .act_zero_w (act_zero_w),
  .pwm_o      (pwm_o)
);

// File: tb/sim_pwm_acc_bank.sv
`timescale 1ns/1ps
module sim_pwm_acc_bank;
  localparam int N_CH = 2, BU_W = 16, ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [N_CH-1:0]   pwm_o;

  always #2 clk = ~clk;

  pwm_acc_bank #(.N_CH(N_CH), .BU_W(BU_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  typedef struct {
    int          kind;  // 0: register read, 1: high-count over len cycles
    int          ch;
    logic [31:0] exp;
    int          len;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // monitor
  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        item_t it;
        logic [31:0] act;
        it = q[0];
        if (it.kind == 0) begin
          @(negedge clk);
          act = rdata_o;
        end else begin
          act = '0;
          for (int k = 0; k < it.len; k++) begin
            @(negedge clk);
            act += 32'(pwm_o[it.ch]);
          end
        end
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic wr(input int ch, input logic [31:0] d);
    @(posedge clk); #1;
    addr_i = ADDR_W'(ch * 32'h400); wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd_exp(input int ch, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr_i = ADDR_W'(ch * 32'h400);
    it.kind = 0; it.ch = ch; it.exp = e; it.len = 0; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic cnt_exp(input int ch, input int len, input int e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.kind = 1; it.ch = ch; it.exp = 32'(e); it.len = len; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    idle(3); #1 rst_ni = 1'b1;
    // R1 reset state
    rd_exp(0, 32'h0, "R1 ch0 reset");
    rd_exp(1, 32'h0, "R1 ch1 reset");
    cnt_exp(0, 8, 0, "R1 ch0 output low");
    // R10 shadow-only write, disabled
    wr(0, 32'h0010_0080);
    rd_exp(0, 32'h0010_0080, "R10 shadow readback");
    cnt_exp(0, 16, 0, "R10 no output from shadow");
    // R6 enable+update with zero active base commits at once
    wr(0, 32'hC010_0080);
    idle(3);
    rd_exp(0, 32'h8010_0080, "R6 immediate commit");
    cnt_exp(0, 32, 16, "R7 R8 ch0 half duty, period 16");
    cnt_exp(1, 16, 0, "R9 ch1 untouched");
    // R3/R4 pending update on ch1 with a long period
    wr(1, 32'hC001_0000);
    wr(1, 32'hC002_0010);
    rd_exp(1, 32'hC002_0010, "R3 pending bit visible");
    wr(1, 32'h0003_0000);
    rd_exp(1, 32'hC002_0010, "R4 write during pending dropped");
    rd_exp(0, 32'h8010_0080, "R9 ch0 unaffected by ch1 writes");
    idle(300);
    rd_exp(1, 32'h8002_0010, "R3 cleared at boundary");
    cnt_exp(1, 128, 120, "R7 R8 ch1 period 128 duty 0x10");
    wr(1, 32'h8004_0010);
    rd_exp(1, 32'h8004_0010, "R10 shadow changed");
    cnt_exp(1, 128, 120, "R10 output unchanged");
    // R8 extremes
    wr(0, 32'hC010_00FF);
    idle(40);
    rd_exp(0, 32'h8010_00FF, "R3 ch0 commit 0xFF");
    cnt_exp(0, 32, 0, "R8 divisor 0xFF low");
    wr(0, 32'hC010_0000);
    idle(40);
    cnt_exp(0, 32, 32, "R8 divisor 0x00 high");
    // R5 disable and commit while disabled
    wr(0, 32'h0010_0080);
    cnt_exp(0, 16, 0, "R5 disabled low");
    wr(0, 32'h4040_0020);
    idle(3);
    rd_exp(0, 32'h0040_0020, "R5 commit while disabled");
    wr(0, 32'h8040_0020);
    idle(2);
    cnt_exp(0, 32, 24, "R5 R7 committed settings, period 4");
    // R6 zero base then recovery
    wr(0, 32'hC000_0080);
    idle(10);
    rd_exp(0, 32'h8000_0080, "R3 commit of zero base");
    cnt_exp(0, 16, 0, "R7 zero base gives no cycles");
    wr(0, 32'hC010_0080);
    idle(3);
    rd_exp(0, 32'h8010_0080, "R6 commit with zero active base");
    cnt_exp(0, 32, 16, "R6 output resumes");
    // R2 reserved bits
    wr(0, 32'h3F00_4011);
    rd_exp(0, 32'h0000_4011, "R2 reserved read zero");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule